// File: doc/BRIEF.md
# Transaction ID Prefixer and Response Router

This block sits between a set of master-side slots and the shared fabric of a crossbar. On the request side it builds the fabric-wide transaction ID for every slot. It takes the slot's own thread bits and places them in the low positions of a fixed per-slot base value. The high bits of that base act as a constant master tag for the slot. The write-address and read-address channels each have their own prefix path.

On the response side, the write-response (B) and read-data (R) channels each get a decoder. The decoder compares the incoming response ID against every slot's tagged range. It produces a one-hot slot select, an error flag when no slot owns the ID, and the thread bits to hand back to the owning master.

Each slot's range is aligned and a power of two in size. A slot with no thread bits owns exactly one ID value and ignores its thread input. Every output is registered once, so results appear one clock after the inputs are sampled.

Top module: `txn_id_router`

## Requirements
- R1: While synchronous reset `rst_i` is high, and in the first cycle after it, every output is zero.
- R2: One clock after sampling, the slice `[s*ID_W +: ID_W]` of `wr_id_o` (and of `rd_id_o`) holds slot s's base ID ORed with the low TW(s) bits of that slot's thread slice `[s*THR_MAX +: THR_MAX]` of `wr_thr_i` (resp. `rd_thr_i`). The default map is: slot 0 base 0x00, width 4; slot 1 base 0x10, width 0; slot 2 base 0x14, width 2; slot 3 base 0x20, width 3.
- R3: Thread input bits at or above a slot's width have no effect on its ID, so a width-0 slot always emits exactly its base.
- R4: A valid response is owned by slot s when the response ID bits at and above TW(s) equal the same bits of slot s's base. Bit s of the select output is then high one clock later.
- R5: A width-0 slot is selected only by its exact base value. Adjacent values do not select it.
- R6: A valid response that no slot owns raises the miss output for exactly one cycle, with a zero select and zero thread bits.
- R7: The returned thread output carries the low TW(s) bits of the response ID of the owning slot, with zeros above them.
- R8: A cycle with the valid input low yields zero select, low miss and zero thread bits on the next cycle, whatever the ID input holds.
- R9: The B and R decoders, and the write and read prefix paths, work independently and concurrently in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| wr_thr_i | input | NUM_SLOTS*THR_MAX | Write-address thread bits, one slice per slot |
| rd_thr_i | input | NUM_SLOTS*THR_MAX | Read-address thread bits, one slice per slot |
| wr_id_o | output | NUM_SLOTS*ID_W | Full write-address ID per slot |
| rd_id_o | output | NUM_SLOTS*ID_W | Full read-address ID per slot |
| b_valid_i | input | 1 | Write response present |
| b_id_i | input | ID_W | Write response ID |
| b_sel_o | output | NUM_SLOTS | One-hot owning slot of the write response |
| b_miss_o | output | 1 | Write response ID owned by no slot |
| b_thr_o | output | THR_MAX | Thread bits returned for the write response |
| r_valid_i | input | 1 | Read response present |
| r_id_i | input | ID_W | Read response ID |
| r_sel_o | output | NUM_SLOTS | One-hot owning slot of the read response |
| r_miss_o | output | 1 | Read response ID owned by no slot |
| r_thr_o | output | THR_MAX | Thread bits returned for the read response |

## Verification
The bench drives every value at the edges of each range: the first and last ID of a wide slot, and the single ID of the width-0 slot. A decoder that compared too few bits would accept the holes next to the width-0 slot. One that compared too many would reject thread values inside a range. It sets thread bits above each slot's width and on the width-0 slot, which exposes a prefixer that lets stray bits leak into the master tag. Unowned IDs check that the miss flag lasts only one cycle and that a design does not raise a stale select or leak thread bits. A mixed cycle, with one hit on one channel and a miss on the other, catches cross-wired decoders.

// File: rtl/txn_id_router_pkg.sv
package txn_id_router_pkg;

    // Mask with the low w bits set (w up to 32).
    function automatic logic [31:0] low_mask(input int unsigned w);
        if (w == 0) begin
            return 32'h0;
        end
        return 32'hFFFF_FFFF >> (32 - w);
    endfunction

endpackage

// File: rtl/txn_id_prefix.sv
module txn_id_prefix
    import txn_id_router_pkg::*;
#(
    parameter int unsigned NUM_SLOTS = 4,
    parameter int unsigned ID_W      = 8,
    parameter int unsigned THR_MAX   = 4,
    parameter logic [NUM_SLOTS*ID_W-1:0] BASE_IDS   = '0,
    parameter logic [NUM_SLOTS*8-1:0]    THR_WIDTHS = '0
) (
    input  logic [NUM_SLOTS*THR_MAX-1:0] thr_i,
    output logic [NUM_SLOTS*ID_W-1:0]    id_o
);

    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
        localparam int unsigned       TW   = int'(THR_WIDTHS[s*8 +: 8]);
        localparam logic [ID_W-1:0]   BASE = BASE_IDS[s*ID_W +: ID_W];
        localparam logic [THR_MAX-1:0] KEEP = THR_MAX'(low_mask(TW));

        logic [THR_MAX-1:0] kept;

        // Bits above the slot's width are masked off, so a width-0 slot
        // contributes nothing but its base.
        always_comb begin
            kept = thr_i[s*THR_MAX +: THR_MAX] & KEEP;
        end

        assign id_o[s*ID_W +: ID_W] = BASE | ID_W'(kept);
    end

endmodule

// File: rtl/txn_id_decode.sv
module txn_id_decode
    import txn_id_router_pkg::*;
#(
    parameter int unsigned NUM_SLOTS = 4,
    parameter int unsigned ID_W      = 8,
    parameter int unsigned THR_MAX   = 4,
    parameter logic [NUM_SLOTS*ID_W-1:0] BASE_IDS   = '0,
    parameter logic [NUM_SLOTS*8-1:0]    THR_WIDTHS = '0
) (
    input  logic                 valid_i,
    input  logic [ID_W-1:0]      id_i,
    output logic [NUM_SLOTS-1:0] sel_o,
    output logic                 miss_o,
    output logic [THR_MAX-1:0]   thr_o
);

    logic [NUM_SLOTS-1:0]         hit;
    logic [NUM_SLOTS*THR_MAX-1:0] thr_part;

    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_match
        localparam int unsigned        TW    = int'(THR_WIDTHS[s*8 +: 8]);
        localparam logic [ID_W-1:0]    BASE  = BASE_IDS[s*ID_W +: ID_W];
        localparam logic [ID_W-1:0]    TAGM  = ~ID_W'(low_mask(TW));
        localparam logic [THR_MAX-1:0] LOWM  = THR_MAX'(low_mask(TW));

        // Tag compare: only the bits at and above the slot's thread width.
        assign hit[s] = valid_i && ((id_i & TAGM) == (BASE & TAGM));
        assign thr_part[s*THR_MAX +: THR_MAX] =
            hit[s] ? (id_i[THR_MAX-1:0] & LOWM) : '0;
    end

    // Ranges never overlap, so at most one part is non-zero: OR-merge.
    always_comb begin
        thr_o = '0;
        for (int s = 0; s < NUM_SLOTS; s++) begin
            thr_o = thr_o | thr_part[s*THR_MAX +: THR_MAX];
        end
    end

    assign sel_o  = hit;
    assign miss_o = valid_i && (hit == '0);

endmodule

// File: rtl/txn_id_router.sv
module txn_id_router
#(
    parameter int unsigned NUM_SLOTS = 4,
    parameter int unsigned ID_W      = 8,
    parameter int unsigned THR_MAX   = 4,
    parameter logic [NUM_SLOTS*ID_W-1:0] BASE_IDS   = {8'h20, 8'h14, 8'h10, 8'h00},
    parameter logic [NUM_SLOTS*8-1:0]    THR_WIDTHS = {8'd3, 8'd2, 8'd0, 8'd4}
) (
    input  logic                         clk_i,
    input  logic                         rst_i,
    input  logic [NUM_SLOTS*THR_MAX-1:0] wr_thr_i,
    input  logic [NUM_SLOTS*THR_MAX-1:0] rd_thr_i,
    output logic [NUM_SLOTS*ID_W-1:0]    wr_id_o,
    output logic [NUM_SLOTS*ID_W-1:0]    rd_id_o,
    input  logic                         b_valid_i,
    input  logic [ID_W-1:0]              b_id_i,
    output logic [NUM_SLOTS-1:0]         b_sel_o,
    output logic                         b_miss_o,
    output logic [THR_MAX-1:0]           b_thr_o,
    input  logic                         r_valid_i,
    input  logic [ID_W-1:0]              r_id_i,
    output logic [NUM_SLOTS-1:0]         r_sel_o,
    output logic                         r_miss_o,
    output logic [THR_MAX-1:0]           r_thr_o
);

    localparam int unsigned FULL_W = NUM_SLOTS * ID_W;

    typedef struct packed {
        logic [FULL_W-1:0]    wr_id;
        logic [FULL_W-1:0]    rd_id;
        logic [NUM_SLOTS-1:0] b_sel;
        logic                 b_miss;
        logic [THR_MAX-1:0]   b_thr;
        logic [NUM_SLOTS-1:0] r_sel;
        logic                 r_miss;
        logic [THR_MAX-1:0]   r_thr;
    } state_t;

    state_t st_d, st_q;

    logic [FULL_W-1:0]    wr_full, rd_full;
    logic [NUM_SLOTS-1:0] b_sel_c, r_sel_c;
    logic                 b_miss_c, r_miss_c;
    logic [THR_MAX-1:0]   b_thr_c, r_thr_c;

    txn_id_prefix #(
        .NUM_SLOTS(NUM_SLOTS), .ID_W(ID_W), .THR_MAX(THR_MAX),
        .BASE_IDS(BASE_IDS), .THR_WIDTHS(THR_WIDTHS)
    ) u_wr_prefix (
        .thr_i(wr_thr_i),
        .id_o (wr_full)
    );

    txn_id_prefix #(
        .NUM_SLOTS(NUM_SLOTS), .ID_W(ID_W), .THR_MAX(THR_MAX),
        .BASE_IDS(BASE_IDS), .THR_WIDTHS(THR_WIDTHS)
    ) u_rd_prefix (
        .thr_i(rd_thr_i),
        .id_o (rd_full)
    );

    txn_id_decode #(
        .NUM_SLOTS(NUM_SLOTS), .ID_W(ID_W), .THR_MAX(THR_MAX),
        .BASE_IDS(BASE_IDS), .THR_WIDTHS(THR_WIDTHS)
    ) u_b_decode (
        .valid_i(b_valid_i),
        .id_i   (b_id_i),
        .sel_o  (b_sel_c),
        .miss_o (b_miss_c),
        .thr_o  (b_thr_c)
    );

    txn_id_decode #(
        .NUM_SLOTS(NUM_SLOTS), .ID_W(ID_W), .THR_MAX(THR_MAX),
        .BASE_IDS(BASE_IDS), .THR_WIDTHS(THR_WIDTHS)
    ) u_r_decode (
        .valid_i(r_valid_i),
        .id_i   (r_id_i),
        .sel_o  (r_sel_c),
        .miss_o (r_miss_c),
        .thr_o  (r_thr_c)
    );

    always_comb begin
        st_d        = st_q;
        st_d.wr_id  = wr_full;
        st_d.rd_id  = rd_full;
        st_d.b_sel  = b_sel_c;
        st_d.b_miss = b_miss_c;
        st_d.b_thr  = b_thr_c;
        st_d.r_sel  = r_sel_c;
        st_d.r_miss = r_miss_c;
        st_d.r_thr  = r_thr_c;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign wr_id_o  = st_q.wr_id;
    assign rd_id_o  = st_q.rd_id;
    assign b_sel_o  = st_q.b_sel;
    assign b_miss_o = st_q.b_miss;
    assign b_thr_o  = st_q.b_thr;
    assign r_sel_o  = st_q.r_sel;
    assign r_miss_o = st_q.r_miss;
    assign r_thr_o  = st_q.r_thr;

endmodule

// File: rtl/txn_id_router_chk.sv
module txn_id_router_chk
    import txn_id_router_pkg::*;
#(
    parameter int unsigned NUM_SLOTS = 4,
    parameter int unsigned ID_W      = 8,
    parameter int unsigned THR_MAX   = 4,
    parameter logic [NUM_SLOTS*ID_W-1:0] BASE_IDS   = '0,
    parameter logic [NUM_SLOTS*8-1:0]    THR_WIDTHS = '0
) (
    input logic                         clk_i,
    input logic                         rst_i,
    input logic [NUM_SLOTS*THR_MAX-1:0] wr_thr_i,
    input logic [NUM_SLOTS*THR_MAX-1:0] rd_thr_i,
    input logic [NUM_SLOTS*ID_W-1:0]    wr_id_o,
    input logic [NUM_SLOTS*ID_W-1:0]    rd_id_o,
    input logic                         b_valid_i,
    input logic [ID_W-1:0]              b_id_i,
    input logic [NUM_SLOTS-1:0]         b_sel_o,
    input logic                         b_miss_o,
    input logic [THR_MAX-1:0]           b_thr_o,
    input logic                         r_valid_i,
    input logic [ID_W-1:0]              r_id_i,
    input logic [NUM_SLOTS-1:0]         r_sel_o,
    input logic                         r_miss_o,
    input logic [THR_MAX-1:0]           r_thr_o
);

    // R4: never more than one owner
    p_b_onehot_r4: assert property (@(posedge clk_i) disable iff (rst_i)
        $onehot0(b_sel_o));
    p_r_onehot_r4: assert property (@(posedge clk_i) disable iff (rst_i)
        $onehot0(r_sel_o));

    // R6: a valid response yields exactly one of hit or miss
    p_b_outcome_r6: assert property (@(posedge clk_i) disable iff (rst_i)
        b_valid_i |=> (b_miss_o ^ (b_sel_o != '0)));
    p_r_outcome_r6: assert property (@(posedge clk_i) disable iff (rst_i)
        r_valid_i |=> (r_miss_o ^ (r_sel_o != '0)));

    // R6: miss carries no thread bits
    p_b_miss_thr_r6: assert property (@(posedge clk_i) disable iff (rst_i)
        b_miss_o |-> (b_thr_o == '0));
    p_r_miss_thr_r6: assert property (@(posedge clk_i) disable iff (rst_i)
        r_miss_o |-> (r_thr_o == '0));

    // R8: idle cycle gives quiet outputs next cycle
    p_b_idle_r8: assert property (@(posedge clk_i) disable iff (rst_i)
        !b_valid_i |=> (b_sel_o == '0 && !b_miss_o && b_thr_o == '0));
    p_r_idle_r8: assert property (@(posedge clk_i) disable iff (rst_i)
        !r_valid_i |=> (r_sel_o == '0 && !r_miss_o && r_thr_o == '0));

    // R3: master tag bits of every slot's outgoing ID are constant
    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_tag
        localparam int unsigned     TW   = int'(THR_WIDTHS[s*8 +: 8]);
        localparam logic [ID_W-1:0] BASE = BASE_IDS[s*ID_W +: ID_W];
        localparam logic [ID_W-1:0] TAGM = ~ID_W'(low_mask(TW));

        p_wr_tag_r3: assert property (@(posedge clk_i) disable iff (rst_i)
            !rst_i |=> ((wr_id_o[s*ID_W +: ID_W] & TAGM) == (BASE & TAGM)));
        p_rd_tag_r3: assert property (@(posedge clk_i) disable iff (rst_i)
            !rst_i |=> ((rd_id_o[s*ID_W +: ID_W] & TAGM) == (BASE & TAGM)));
    end

endmodule

bind txn_id_router txn_id_router_chk #(
    .NUM_SLOTS(NUM_SLOTS), .ID_W(ID_W), .THR_MAX(THR_MAX),
    .BASE_IDS(BASE_IDS), .THR_WIDTHS(THR_WIDTHS)
) u_chk (.*);

// File: tb/txn_id_router_bench.sv
`timescale 1ns/1ps
module txn_id_router_bench;

    localparam int NS = 4;
    localparam int IW = 8;
    localparam int TM = 4;

    // Default map from R2: base and width per slot
    localparam logic [7:0] BASES [NS] = '{8'h00, 8'h10, 8'h14, 8'h20};
    localparam int         WIDTHS[NS] = '{4, 0, 2, 3};

    logic              clk = 1'b0;
    logic              rst;
    logic [NS*TM-1:0]  wr_thr, rd_thr;
    logic [NS*IW-1:0]  wr_id, rd_id;
    logic              b_valid, r_valid;
    logic [IW-1:0]     b_id, r_id;
    logic [NS-1:0]     b_sel, r_sel;
    logic              b_miss, r_miss;
    logic [TM-1:0]     b_thr, r_thr;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    txn_id_router u_txn_id_router (
        .clk_i(clk), .rst_i(rst),
        .wr_thr_i(wr_thr), .rd_thr_i(rd_thr),
        .wr_id_o(wr_id), .rd_id_o(rd_id),
        .b_valid_i(b_valid), .b_id_i(b_id),
        .b_sel_o(b_sel), .b_miss_o(b_miss), .b_thr_o(b_thr),
        .r_valid_i(r_valid), .r_id_i(r_id),
        .r_sel_o(r_sel), .r_miss_o(r_miss), .r_thr_o(r_thr)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] lmask(input int w);
        return 8'((1 << w) - 1);
    endfunction

    function automatic logic [7:0] exp_req(input int s, input logic [TM-1:0] t);
        return BASES[s] | (8'(t) & lmask(WIDTHS[s]));
    endfunction

    task automatic exp_resp(input logic v, input logic [7:0] id,
                            output logic [NS-1:0] sel, output logic miss,
                            output logic [TM-1:0] thr);
        sel = '0; thr = '0; miss = 1'b0;
        if (v) begin
            for (int s = 0; s < NS; s++) begin
                if ((id & ~lmask(WIDTHS[s])) == (BASES[s] & ~lmask(WIDTHS[s]))) begin
                    sel[s] = 1'b1;
                    thr    = TM'(id & lmask(WIDTHS[s]));
                end
            end
            miss = (sel == '0);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic check_b(input string req, input logic v, input logic [7:0] id);
        logic [NS-1:0] es; logic em; logic [TM-1:0] et;
        exp_resp(v, id, es, em, et);
        chk(req, $sformatf("b_sel id=%0h", id),  32'(b_sel),  32'(es));
        chk(req, $sformatf("b_miss id=%0h", id), 32'(b_miss), 32'(em));
        chk(req, $sformatf("b_thr id=%0h", id),  32'(b_thr),  32'(et));
    endtask

    task automatic check_r(input string req, input logic v, input logic [7:0] id);
        logic [NS-1:0] es; logic em; logic [TM-1:0] et;
        exp_resp(v, id, es, em, et);
        chk(req, $sformatf("r_sel id=%0h", id),  32'(r_sel),  32'(es));
        chk(req, $sformatf("r_miss id=%0h", id), 32'(r_miss), 32'(em));
        chk(req, $sformatf("r_thr id=%0h", id),  32'(r_thr),  32'(et));
    endtask

    // R1: reset state
    task automatic t_reset();
        @(negedge clk);
        rst = 1'b1; wr_thr = '1; rd_thr = '1;
        b_valid = 1'b1; b_id = 8'h10; r_valid = 1'b1; r_id = 8'h10;
        step(); step();
        chk("R1", "wr_id", wr_id, '0);
        chk("R1", "rd_id", rd_id, '0);
        chk("R1", "b_sel", 32'(b_sel), 0);
        chk("R1", "r_sel", 32'(r_sel), 0);
        chk("R1", "miss", 32'({b_miss, r_miss}), 0);
        @(negedge clk);
        b_valid = 1'b0; r_valid = 1'b0;
        rst = 1'b0;
        #1;
        chk("R1", "first cycle wr_id", wr_id, '0);
    endtask

    // R2, R3: prefix paths under several thread patterns
    task automatic t_request();
        logic [NS*TM-1:0] pats [4] = '{16'hFFFA, 16'h0000, 16'h5A3C, 16'h8F71};
        for (int p = 0; p < 4; p++) begin
            @(negedge clk);
            wr_thr = pats[p];
            rd_thr = ~pats[p];
            step();
            for (int s = 0; s < NS; s++) begin
                chk(WIDTHS[s] == 0 ? "R3" : "R2", $sformatf("wr slot%0d", s),
                    32'(wr_id[s*IW +: IW]), 32'(exp_req(s, pats[p][s*TM +: TM])));
                chk("R3", $sformatf("rd slot%0d", s),
                    32'(rd_id[s*IW +: IW]), 32'(exp_req(s, ~pats[p][s*TM +: TM])));
            end
        end
    endtask

    // R4, R5, R7: owned IDs at range edges
    task automatic t_hits();
        logic [7:0] ids [7] = '{8'h00, 8'h0F, 8'h09, 8'h10, 8'h14, 8'h17, 8'h27};
        for (int i = 0; i < 7; i++) begin
            @(negedge clk);
            b_valid = 1'b1; b_id = ids[i];
            r_valid = 1'b1; r_id = ids[6 - i];
            step();
            check_b(ids[i] == 8'h10 ? "R5" : "R4", 1'b1, ids[i]);
            check_r("R7", 1'b1, ids[6 - i]);
        end
        @(negedge clk);
        b_valid = 1'b0; r_valid = 1'b0;
    endtask

    // R5, R6: unowned IDs, miss lasts one cycle
    task automatic t_miss();
        logic [7:0] ids [5] = '{8'h11, 8'h13, 8'h18, 8'h30, 8'hFF};
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            b_valid = 1'b1; b_id = ids[i];
            step();
            check_b(i < 2 ? "R5" : "R6", 1'b1, ids[i]);
            chk("R6", "b_miss asserted", 32'(b_miss), 1);
            @(negedge clk);
            b_valid = 1'b0;
            step();
            chk("R6", "b_miss one cycle", 32'(b_miss), 0);
        end
    endtask

    // R8: ID ignored while valid low
    task automatic t_idle();
        @(negedge clk);
        b_valid = 1'b0; b_id = 8'h10;
        r_valid = 1'b0; r_id = 8'hFF;
        step();
        check_b("R8", 1'b0, b_id);
        check_r("R8", 1'b0, r_id);
    endtask

    // R9: both channels in one cycle, one hits and one misses
    task automatic t_concurrent();
        @(negedge clk);
        b_valid = 1'b1; b_id = 8'h15;
        r_valid = 1'b1; r_id = 8'h40;
        step();
        check_b("R9", 1'b1, 8'h15);
        check_r("R9", 1'b1, 8'h40);
        @(negedge clk);
        b_valid = 1'b1; b_id = 8'h50;
        r_valid = 1'b1; r_id = 8'h23;
        step();
        check_b("R9", 1'b1, 8'h50);
        check_r("R9", 1'b1, 8'h23);
        @(negedge clk);
        b_valid = 1'b0; r_valid = 1'b0;
    endtask

    initial begin
        rst = 1'b1; wr_thr = '0; rd_thr = '0;
        b_valid = 1'b0; b_id = '0; r_valid = 1'b0; r_id = '0;
        t_reset();
        t_request();
        t_hits();
        t_miss();
        t_idle();
        t_concurrent();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule